// File: doc/BRIEF.md
# Reference-Trimmed Fractional Clock Divider

This block derives a slow output clock from a fast system clock with a phase accumulator. On every system clock cycle a frequency word is added to an accumulator, and the accumulator's top bit is the output clock. The output rate is therefore `word / 2^ACC_W` of the system clock, and the divide ratio can be fractional. The default configuration makes a 12800 Hz output from a nominal 100 MHz oscillator, which is a ratio of about 7812.5.

The real oscillator drifts away from its nominal rate, so the frequency word is not fixed. A once-per-second reference pulse is synchronised into the clock domain. Between consecutive reference edges the block counts the output's rising edges. At each edge it compares that count with the target rate and adds the signed error, shifted right by a selectable amount, to a fixed-point frequency word. The word carries `FRAC_W` extra fractional bits below the part that feeds the accumulator. The word is held inside a band of plus or minus `CLAMP_PPM` around nominal, so a lost or spurious reference cannot push the output far off frequency.

A host can load a starting word at any time. A lock flag rises once enough consecutive seconds have passed with no count error.

Top module: `pps_frac_clkdiv`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `freq_word` equals the nominal word `round(OUT_HZ*2^ACC_W/CLK_HZ) * 2^FRAC_W`, and both `clk_out` and `locked` are 0.
- R2: `clk_out` is bit `ACC_W-1` of an accumulator that starts at 0 after reset and adds `freq_word >> FRAC_W` on every cycle. At the nominal word in the small configuration (word 512, 16-bit accumulator), this gives a 128-cycle period with 64 cycles high.
- R3: At every synchronised reference edge except the first after reset, `freq_word` becomes `freq_word + (((OUT_HZ - n) * 2^FRAC_W) >>> gain_shift)`, then clamped. Here `n` is the number of `clk_out` rising edges since the previous reference edge and `>>>` is an arithmetic shift.
- R4: The first reference edge after reset only opens the measurement window and leaves `freq_word` unchanged.
- R5: `freq_word` changes only on a trimming reference edge (R3) or a host load (R8). A trimming edge whose count error is zero leaves it unchanged.
- R6: `locked` rises on the reference edge that completes `LOCK_SECS` consecutive trimming windows with zero error. It falls on any trimming edge with a nonzero error, and on a host load.
- R7: `freq_word` always lies within `nominal ± floor(nominal*CLAMP_PPM/10^6)`. Any result outside that band is replaced by the nearer bound.
- R8: A cycle with `init_load` high sets `freq_word` to `init_inc * 2^FRAC_W`, clamped as in R7, and clears `locked`. A load takes priority over a trim in the same cycle.
- R9: `pps_in` passes through a two-stage synchroniser. A reference pulse that stays high for many cycles causes exactly one trim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pps_in | input | 1 | Once-per-second reference, asynchronous |
| gain_shift | input | SHIFT_W | Right shift applied to the scaled count error |
| init_load | input | 1 | Load `init_inc` into the frequency word |
| init_inc | input | ACC_W | Host starting word (integer part) |
| clk_out | output | 1 | Divided clock (accumulator top bit) |
| locked | output | 1 | Loop has seen `LOCK_SECS` error-free seconds |
| freq_word | output | ACC_W+FRAC_W | Current fixed-point frequency word |

## Verification
The embedded assertions check the following on every cycle:
- the frequency word stays inside the clamp band;
- the word is held between reference edges and loads, and across the first reference edge;
- the lock flag rises only on a reference edge;
- output rise pulses and synchronised edges never last two cycles.

The exact trim arithmetic can only be shown by the bench's scenarios, which use reference spacings that give a known output-edge count. This covers the effect of the shift, the clamping to each bound, the lock and unlock sequence, and the output period and duty.

// File: rtl/frac_div_pkg.sv
// Package: shared types and constant helpers for the reference-trimmed divider.
// Assumes out_hz << acc_w fits in 64 bits.
package frac_div_pkg;

    typedef enum logic {
        LOOP_IDLE,
        LOOP_ARMED
    } loop_state_t;

    // Nominal accumulator step, rounded to nearest.
    function automatic longint unsigned nominal_step(input int unsigned acc_w,
                                                     input longint unsigned clk_hz,
                                                     input longint unsigned out_hz);
        return ((out_hz << acc_w) + (clk_hz / 2)) / clk_hz;
    endfunction

    // Half-width of the allowed band around a nominal word, in ppm.
    function automatic longint unsigned clamp_span(input longint unsigned nom,
                                                   input longint unsigned ppm);
        return (nom * ppm) / 64'd1000000;
    endfunction

endpackage

// File: rtl/pfd_pps_sync.sv
// Module: two-stage synchroniser and rising-edge detector for the reference pulse.
// Assumes pps_in is asynchronous and stays high for at least one clock cycle.
module pfd_pps_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pps_in,
    output logic pps_edge
);
    logic meta_q;
    logic sync_q;
    logic sync_d;

    // Sample the raw reference into the clock domain and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            sync_d <= 1'b0;
        end else begin
            meta_q <= pps_in;
            sync_q <= meta_q;
            sync_d <= sync_q;
        end
    end

    assign pps_edge = sync_q & ~sync_d;

    // R9: a synchronised edge is a single-cycle pulse
    assert_single_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pps_edge |=> !pps_edge);

endmodule

// File: rtl/pfd_phase_acc.sv
// Module: phase accumulator; the top bit is the divided clock.
// Assumes step < 2^(ACC_W-1), so the top bit never rises on two cycles in a row.
module pfd_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] step,
    output logic             clk_out,
    output logic             out_rise
);
    logic [ACC_W-1:0] acc_q;
    logic             top_d;

    // Advance the phase by the current step and remember the previous top bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            top_d <= 1'b0;
        end else begin
            acc_q <= acc_q + step;
            top_d <= acc_q[ACC_W-1];
        end
    end

    assign clk_out  = acc_q[ACC_W-1];
    assign out_rise = acc_q[ACC_W-1] & ~top_d;

    // R2: each output rising edge is seen for exactly one cycle
    assert_rise_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_rise |=> !out_rise);

endmodule

// File: rtl/pfd_trim_loop.sv
// Module: counts output edges per reference second and trims the fixed-point
// frequency word, with clamping, a lock detector and a host load.
// Assumes OUT_HZ < 2^CNT_W and that pps_edge is a single-cycle pulse.
module pfd_trim_loop
    import frac_div_pkg::*;
#(
    parameter int ACC_W     = 32,
    parameter int FRAC_W    = 8,
    parameter int CNT_W     = 15,
    parameter int OUT_HZ    = 12800,
    parameter int LOCK_SECS = 16,
    parameter int SHIFT_W   = 4,
    parameter logic [ACC_W+FRAC_W-1:0] NOM_FX = '0,
    parameter logic [ACC_W+FRAC_W-1:0] HI_FX  = '0,
    parameter logic [ACC_W+FRAC_W-1:0] LO_FX  = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pps_edge,
    input  logic                    out_rise,
    input  logic [SHIFT_W-1:0]      gain_shift,
    input  logic                    init_load,
    input  logic [ACC_W-1:0]        init_inc,
    output logic [ACC_W+FRAC_W-1:0] inc_fx,
    output logic                    locked
);
    localparam int IW  = ACC_W + FRAC_W;
    localparam int XW  = IW + 2;
    localparam int EW  = CNT_W + 1;
    localparam int STW = $clog2(LOCK_SECS + 1);
    localparam logic [CNT_W-1:0] TARGET  = CNT_W'(OUT_HZ);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [STW-1:0]   STR_MAX = STW'(LOCK_SECS);
    localparam logic signed [XW-1:0] HI_X = $signed({2'b00, HI_FX});
    localparam logic signed [XW-1:0] LO_X = $signed({2'b00, LO_FX});

    loop_state_t           loop_st;
    logic [CNT_W-1:0]      edge_cnt;
    logic [STW-1:0]        streak;
    logic signed [EW-1:0]  cnt_err;
    logic signed [XW-1:0]  err_x;
    logic signed [XW-1:0]  step_x;
    logic signed [XW-1:0]  sum_x;
    logic [IW-1:0]         trim_nx;
    logic [IW-1:0]         load_raw;
    logic [IW-1:0]         load_nx;
    logic [STW-1:0]        streak_nx;

    // Form the scaled error, the clamped trimmed word and the clamped load word.
    always_comb begin
        cnt_err   = $signed({1'b0, TARGET}) - $signed({1'b0, edge_cnt});
        err_x     = XW'(cnt_err);
        step_x    = (err_x <<< FRAC_W) >>> gain_shift;
        sum_x     = $signed({2'b00, inc_fx}) + step_x;
        if (sum_x > HI_X)      trim_nx = HI_FX;
        else if (sum_x < LO_X) trim_nx = LO_FX;
        else                   trim_nx = sum_x[IW-1:0];
        load_raw  = {init_inc, {FRAC_W{1'b0}}};
        if (load_raw > HI_FX)      load_nx = HI_FX;
        else if (load_raw < LO_FX) load_nx = LO_FX;
        else                       load_nx = load_raw;
        streak_nx = (streak == STR_MAX) ? streak : streak + 1'b1;
    end

    // Count output edges in the current window; restart at each reference edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            edge_cnt <= '0;
        else if (pps_edge)
            edge_cnt <= CNT_W'(out_rise);
        else if (edge_cnt != CNT_MAX)
            edge_cnt <= edge_cnt + CNT_W'(out_rise);
    end

    // Arm the loop on the first reference edge after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        loop_st <= LOOP_IDLE;
        else if (pps_edge) loop_st <= LOOP_ARMED;
    end

    // Update the frequency word, the zero-error streak and the lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_fx <= NOM_FX;
            streak <= '0;
            locked <= 1'b0;
        end else if (init_load) begin
            inc_fx <= load_nx;
            streak <= '0;
            locked <= 1'b0;
        end else if (pps_edge && loop_st == LOOP_ARMED) begin
            inc_fx <= trim_nx;
            if (cnt_err == '0) begin
                streak <= streak_nx;
                locked <= (streak_nx >= STR_MAX);
            end else begin
                streak <= '0;
                locked <= 1'b0;
            end
        end
    end

    // R7: word never leaves the clamp band
    assert_word_in_band_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_fx <= HI_FX) && (inc_fx >= LO_FX));

    // R5: word holds when neither a reference edge nor a load occurs
    assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pps_edge && !init_load) |=> $stable(inc_fx));

    // R4: the arming edge leaves the word untouched
    assert_open_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pps_edge && loop_st == LOOP_IDLE && !init_load) |=> $stable(inc_fx));

    // R6: lock only rises as a result of a reference edge
    assert_lock_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(pps_edge));

endmodule

// File: rtl/pps_frac_clkdiv.sv
// Module: top of the reference-trimmed fractional clock divider.
// Assumes CLAMP_PPM keeps the word well below half the accumulator range.
module pps_frac_clkdiv
    import frac_div_pkg::*;
#(
    parameter int ACC_W     = 32,
    parameter int FRAC_W    = 8,
    parameter longint CLK_HZ = 100000000,
    parameter int OUT_HZ    = 12800,
    parameter int LOCK_SECS = 16,
    parameter int CLAMP_PPM = 2000,
    parameter int SHIFT_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pps_in,
    input  logic [SHIFT_W-1:0]      gain_shift,
    input  logic                    init_load,
    input  logic [ACC_W-1:0]        init_inc,
    output logic                    clk_out,
    output logic                    locked,
    output logic [ACC_W+FRAC_W-1:0] freq_word
);
    localparam int IW    = ACC_W + FRAC_W;
    localparam int CNT_W = $clog2(2 * OUT_HZ + 1);
    localparam longint unsigned NOM    = nominal_step(ACC_W, CLK_HZ, OUT_HZ);
    localparam longint unsigned NOM_FX = NOM << FRAC_W;
    localparam longint unsigned SPAN   = clamp_span(NOM_FX, CLAMP_PPM);
    localparam logic [IW-1:0] NOM_W = IW'(NOM_FX);
    localparam logic [IW-1:0] HI_W  = IW'(NOM_FX + SPAN);
    localparam logic [IW-1:0] LO_W  = IW'(NOM_FX - SPAN);

    logic pps_edge;
    logic out_rise;

    pfd_pps_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pps_in   (pps_in),
        .pps_edge (pps_edge)
    );

    pfd_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (freq_word[IW-1:FRAC_W]),
        .clk_out  (clk_out),
        .out_rise (out_rise)
    );

    pfd_trim_loop #(
        .ACC_W     (ACC_W),
        .FRAC_W    (FRAC_W),
        .CNT_W     (CNT_W),
        .OUT_HZ    (OUT_HZ),
        .LOCK_SECS (LOCK_SECS),
        .SHIFT_W   (SHIFT_W),
        .NOM_FX    (NOM_W),
        .HI_FX     (HI_W),
        .LO_FX     (LO_W)
    ) u_loop (
        .clk        (clk),
        .rst_n      (rst_n),
        .pps_edge   (pps_edge),
        .out_rise   (out_rise),
        .gain_shift (gain_shift),
        .init_load  (init_load),
        .init_inc   (init_inc),
        .inc_fx     (freq_word),
        .locked     (locked)
    );

endmodule

// File: tb/pps_frac_clkdiv_test.sv
// Bench: small configuration (16-bit accumulator, 4096 Hz clock, 32 Hz output)
// where reference spacings give exact edge counts, so trims are computed exactly.
module pps_frac_clkdiv_test;
    localparam int AW = 16;
    localparam int FW = 8;
    localparam int NOMFX = 512 * 256;
    localparam int SPAN  = (NOMFX * 2000) / 1000000;
    localparam int HI    = NOMFX + SPAN;
    localparam int LO    = NOMFX - SPAN;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pps_in = 1'b0;
    logic [3:0]    gain_shift = 4'd0;
    logic          init_load = 1'b0;
    logic [AW-1:0] init_inc = '0;
    logic          clk_out;
    logic          locked;
    logic [AW+FW-1:0] freq_word;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pps_frac_clkdiv #(
        .ACC_W(AW), .FRAC_W(FW), .CLK_HZ(4096), .OUT_HZ(32),
        .LOCK_SECS(3), .CLAMP_PPM(2000), .SHIFT_W(4)
    ) uut (
        .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .gain_shift(gain_shift),
        .init_load(init_load), .init_inc(init_inc), .clk_out(clk_out),
        .locked(locked), .freq_word(freq_word)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic [3:0] sh);
        @(negedge clk);
        rst_n = 1'b0;
        gain_shift = sh;
        idle(5);
        rst_n = 1'b1;
    endtask

    // Pulse the reference for 'hold' cycles; returns hold+6 cycles after the rise.
    task automatic pulse(input int hold);
        pps_in = 1'b1;
        idle(hold);
        pps_in = 1'b0;
        idle(6);
    endtask

    task automatic load_word(input int v);
        init_inc = AW'(v);
        init_load = 1'b1;
        @(negedge clk);
        init_load = 1'b0;
        idle(2);
    endtask

    initial begin
        int hi_n;
        int lo_n;
        // R1: reset values
        @(negedge clk);
        idle(3);
        chk("R1 freq_word in reset", freq_word, NOMFX);
        chk("R1 clk_out in reset", clk_out, 0);
        chk("R1 locked in reset", locked, 0);

        // R2: period and duty at nominal word
        do_reset(4'd0);
        while (clk_out == 1'b0) @(negedge clk);
        hi_n = 0;
        while (clk_out == 1'b1) begin hi_n++; @(negedge clk); end
        lo_n = 0;
        while (clk_out == 1'b0) begin lo_n++; @(negedge clk); end
        chk("R2 high cycles", hi_n, 64);
        chk("R2 period cycles", hi_n + lo_n, 128);

        // R4/R5/R6: exact windows of 4096 cycles (32 output edges)
        do_reset(4'd4);
        idle(20);
        pulse(4);
        chk("R4 word after first edge", freq_word, NOMFX);
        chk("R6 no lock after first edge", locked, 0);
        idle(4096 - 10);
        pulse(4);
        chk("R6 no lock after one clean window", locked, 0);
        idle(4096 - 10);
        pulse(4);
        chk("R5 word unchanged on zero error", freq_word, NOMFX);
        chk("R6 no lock after two clean windows", locked, 0);
        idle(4096 - 10);
        pulse(4);
        chk("R6 lock after three clean windows", locked, 1);
        // R3: 4224-cycle window gives 33 edges, error -1, shift 4 -> -16
        idle(4224 - 10);
        pulse(4);
        chk("R3 trim with shift 4", freq_word, NOMFX - 16);
        chk("R6 lock drops on error", locked, 0);
        idle(50);
        chk("R5 word held between edges", freq_word, NOMFX - 16);

        // R8: host loads, clamped by R7
        load_word(512);
        chk("R8 load nominal", freq_word, NOMFX);
        load_word(520);
        chk("R8 R7 load above band", freq_word, HI);
        load_word(500);
        chk("R8 R7 load below band", freq_word, LO);
        load_word(511);
        chk("R8 load in band", freq_word, 511 * 256);

        // R3/R9: 2048-cycle window (16 edges), error +16, shift 4 -> +256; long pulse
        do_reset(4'd4);
        idle(20);
        pulse(4);
        idle(2048 - 10);
        pulse(100);
        chk("R3 R9 single positive trim", freq_word, NOMFX + 256);

        // R7: shift 0 drives past the upper bound
        do_reset(4'd0);
        idle(20);
        pulse(4);
        idle(2048 - 10);
        pulse(4);
        chk("R7 clamp at upper bound", freq_word, HI);

        // R7: 8192-cycle window (64 edges) drives past the lower bound
        do_reset(4'd0);
        idle(20);
        pulse(4);
        idle(8192 - 10);
        pulse(4);
        chk("R7 clamp at lower bound", freq_word, LO);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule